// File: doc/BRIEF.md
# Serial Transmitter with Inter-Character Gap

This block turns bytes written into a small transmit queue into asynchronous serial frames on a single output line. Each character goes out least significant bit first. The bit period is sixteen times a programmable divisor plus one, in clock cycles. A three-bit mode field selects whether a parity bit is added and which kind: a fixed value, even or odd.

After each stop bit, a programmable gap holds the line idle for a whole number of bit periods before the next start bit. A break control pulls the line low while it is held. A synchronous flush pulse empties the queue and returns the frame sequencer to idle.

The block reports when the queue is full, when it is empty, and when the last character has left the line. A controller typically fills the queue while sending is disabled, sets the format fields, then enables sending. It uses the completion flag to know when the format can safely be changed.

Top module: `uart_gap_tx`

## Requirements
- R1: Every bit on `txd` (start, data, parity, stop) lasts exactly 16 × (`baud_div` + 1) clock cycles.
- R2: A frame is one low start bit, then the eight data bits least significant first, then one high stop bit. Between frames the line idles high.
- R3: A parity bit sits between the last data bit and the stop bit only when `parity_mode[2:1]` is not 00. Modes 010 and 110 send 0, and modes 011 and 111 send 1. Mode 100 sends the XOR of the data bits (even parity), and mode 101 sends its complement (odd parity).
- R4: Suppose the next character is already queued when the stop bit ends. Its start bit then begins exactly `gap_bits` bit periods after that stop bit ends, so a value of 0 gives back-to-back frames.
- R5: In every cycle where `break_force` is 1, `txd` is 0, whether or not a frame is in progress.
- R6: `tx_done` is 1 exactly when the queue is empty and no start, data, parity or stop bit is being sent. It is 0 during a frame's stop bit and 1 once that stop bit has ended with nothing queued.
- R7: A one-cycle `flush` pulse empties the queue and stops any frame in progress. From the next cycle, `txd` is high, `fifo_empty` and `tx_done` are 1, and no queued character is sent. A character written afterwards is sent normally.
- R8: While `tx_enable` is 0, no new frame starts. Queued characters wait, and `txd` stays high.
- R9: `fifo_full` is 1 when `FIFO_DEPTH` characters are queued, and a write made while it is 1 is discarded. `fifo_empty` is 1 when nothing is queued. Characters leave the queue in the order they were written.
- R10: After reset, `txd` is 1, `fifo_empty` is 1, `fifo_full` is 0 and `tx_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the oversampling time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one character into the queue |
| wr_data | input | DATA_W | Character to queue |
| flush | input | 1 | Synchronous pulse: empty the queue and abort the frame |
| tx_enable | input | 1 | Allows new frames to start |
| parity_mode | input | 3 | Parity presence and kind |
| break_force | input | 1 | Holds the line low |
| baud_div | input | DIV_W | Bit period is 16 × (value + 1) cycles |
| gap_bits | input | GAP_W | Idle bit periods after each stop bit |
| txd | output | 1 | Serial output line |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH characters |
| fifo_empty | output | 1 | Queue holds nothing |
| tx_done | output | 1 | Queue empty and line not sending |

## Verification
The properties assume that `parity_mode`, `baud_div` and `gap_bits` stay constant while `tx_done` is 0, and that `flush` is a single-cycle pulse. A format change in the middle of a frame would otherwise make the bit timing and parity checks meaningless. The stimulus changes these fields only after the completion flag has been seen high and the line has had time to settle. Writes and flushes are driven as single-cycle pulses away from the sampling edge.

// File: rtl/uagt_pkg.sv
package uagt_pkg;

   // Frame sequencer states; ordering is not decoded anywhere else.
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4,
      ST_GAP   = 3'd5
   } tx_state_e;

   localparam int unsigned OVERSAMPLE = 16;

   // Parity field helpers: [2:1] nonzero means a parity bit is sent,
   // [2:1] == 10 selects computed parity, otherwise bit [0] is sent as is.
   function automatic logic mode_has_parity(input logic [2:0] m);
      return |m[2:1];
   endfunction

   function automatic logic mode_is_computed(input logic [2:0] m);
      return (m[2:1] == 2'b10);
   endfunction

endpackage

// File: rtl/uagt_fifo.sv
module uagt_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);

   logic push_ok;
   logic pop_ok;
   logic [CW-1:0] count_q;

   assign full    = (count_q == CW'(DEPTH));
   assign empty   = (count_q == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign count   = count_q;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("uagt_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic [W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (push_ok && !flush) begin
               hold_q <= wdata;
            end
         end
         assign rdata = hold_q;
      end else begin : g_ring
         localparam int unsigned AW = $clog2(DEPTH);
         localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
         logic [W-1:0]  mem_q [DEPTH];
         logic [AW-1:0] wp_q;
         logic [AW-1:0] rp_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp_q <= '0;
               rp_q <= '0;
            end else if (flush) begin
               wp_q <= '0;
               rp_q <= '0;
            end else begin
               if (push_ok) begin
                  wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
               end
               if (pop_ok) begin
                  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (push_ok && !flush) begin
               mem_q[wp_q] <= wdata;
            end
         end

         assign rdata = mem_q[rp_q];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (flush) begin
         count_q <= '0;
      end else begin
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

endmodule

// File: rtl/uagt_bit_timer.sv
module uagt_bit_timer #(
   parameter int unsigned DIV_W = 9,
   parameter int unsigned OVS   = 16,
   localparam int unsigned LOG_OVS = (OVS > 1) ? $clog2(OVS) : 0,
   localparam int unsigned CW      = DIV_W + LOG_OVS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             bit_end
);

   logic [CW-1:0] limit;
   logic [CW-1:0] cnt_q;

   generate
      if (OVS < 1 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("uagt_bit_timer: OVS must be a power of two");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("uagt_bit_timer: DIV_W must be at least 1");
      end

      if (OVS == 1) begin : g_plain
         assign limit = div;
      end else begin : g_scaled
         // (div + 1) * OVS - 1 == div * OVS + (OVS - 1)
         assign limit = {div, {LOG_OVS{1'b1}}};
      end
   endgenerate

   assign bit_end = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || !run || bit_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/uagt_frame.sv
module uagt_frame
   import uagt_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned GAP_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              enable,
   input  logic [2:0]        mode,
   input  logic [GAP_W-1:0]  gap,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              bit_end,
   output logic              pop,
   output logic              timer_run,
   output logic              busy,
   output logic              line
);

   localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("uagt_frame: DATA_W must be at least 2");
      end
      if (GAP_W < 1) begin : g_bad_gap
         $error("uagt_frame: GAP_W must be at least 1");
      end
   endgenerate

   tx_state_e         state_q, state_d;
   logic [DATA_W-1:0] shreg_q, shreg_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [GAP_W-1:0]  gcnt_q, gcnt_d;
   logic              par_en_q, par_en_d;
   logic              par_q, par_d;
   logic              can_start;
   logic              load;
   logic              par_calc;

   assign can_start = enable && !fifo_empty;
   assign par_calc  = mode_is_computed(mode) ? ((^fifo_data) ^ mode[0]) : mode[0];

   always_comb begin
      state_d  = state_q;
      shreg_d  = shreg_q;
      idx_d    = idx_q;
      gcnt_d   = gcnt_q;
      par_en_d = par_en_q;
      par_d    = par_q;
      load     = 1'b0;

      unique case (state_q)
         ST_IDLE: begin
            if (can_start) load = 1'b1;
         end
         ST_START: begin
            if (bit_end) begin
               state_d = ST_DATA;
               idx_d   = '0;
            end
         end
         ST_DATA: begin
            if (bit_end) begin
               shreg_d = shreg_q >> 1;
               if (idx_q == LAST_IDX) begin
                  state_d = par_en_q ? ST_PAR : ST_STOP;
               end else begin
                  idx_d = idx_q + 1'b1;
               end
            end
         end
         ST_PAR: begin
            if (bit_end) state_d = ST_STOP;
         end
         ST_STOP: begin
            if (bit_end) begin
               if (gap != '0) begin
                  state_d = ST_GAP;
                  gcnt_d  = gap;
               end else if (can_start) begin
                  load = 1'b1;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         ST_GAP: begin
            if (bit_end) begin
               if (gcnt_q == GAP_W'(1)) begin
                  if (can_start) load = 1'b1;
                  else           state_d = ST_IDLE;
               end else begin
                  gcnt_d = gcnt_q - 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase

      if (load) begin
         state_d  = ST_START;
         shreg_d  = fifo_data;
         par_en_d = mode_has_parity(mode);
         par_d    = par_calc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         shreg_q  <= '0;
         idx_q    <= '0;
         gcnt_q   <= '0;
         par_en_q <= 1'b0;
         par_q    <= 1'b0;
      end else if (flush) begin
         state_q  <= ST_IDLE;
         shreg_q  <= '0;
         idx_q    <= '0;
         gcnt_q   <= '0;
         par_en_q <= 1'b0;
         par_q    <= 1'b0;
      end else begin
         state_q  <= state_d;
         shreg_q  <= shreg_d;
         idx_q    <= idx_d;
         gcnt_q   <= gcnt_d;
         par_en_q <= par_en_d;
         par_q    <= par_d;
      end
   end

   assign pop       = load && !flush;
   assign timer_run = (state_q != ST_IDLE);
   assign busy      = (state_q == ST_START) || (state_q == ST_DATA) ||
                      (state_q == ST_PAR)   || (state_q == ST_STOP);

   always_comb begin
      unique case (state_q)
         ST_START: line = 1'b0;
         ST_DATA:  line = shreg_q[0];
         ST_PAR:   line = par_q;
         default:  line = 1'b1;
      endcase
   end

endmodule

// File: rtl/uart_gap_tx.sv
module uart_gap_tx
   import uagt_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned DIV_W      = 9,
   parameter int unsigned GAP_W      = 4,
   localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              flush,
   input  logic              tx_enable,
   input  logic [2:0]        parity_mode,
   input  logic              break_force,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic [GAP_W-1:0]  gap_bits,
   output logic              txd,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic              tx_done
);

   logic [DATA_W-1:0] head;
   logic [CNT_W-1:0]  count;
   logic              pop;
   logic              timer_run;
   logic              bit_end;
   logic              busy;
   logic              line;

   uagt_fifo #(
      .W     (DATA_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (wr_en),
      .wdata (wr_data),
      .pop   (pop),
      .rdata (head),
      .full  (fifo_full),
      .empty (fifo_empty),
      .count (count)
   );

   uagt_bit_timer #(
      .DIV_W (DIV_W),
      .OVS   (OVERSAMPLE)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (flush),
      .run     (timer_run),
      .div     (baud_div),
      .bit_end (bit_end)
   );

   uagt_frame #(
      .DATA_W (DATA_W),
      .GAP_W  (GAP_W)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .enable     (tx_enable),
      .mode       (parity_mode),
      .gap        (gap_bits),
      .fifo_empty (fifo_empty),
      .fifo_data  (head),
      .bit_end    (bit_end),
      .pop        (pop),
      .timer_run  (timer_run),
      .busy       (busy),
      .line       (line)
   );

   assign txd     = break_force ? 1'b0 : line;
   assign tx_done = fifo_empty && !busy;

endmodule

// File: rtl/uagt_tx_checker.sv
module uagt_tx_checker #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          flush,
   input logic          tx_enable,
   input logic          break_force,
   input logic          txd,
   input logic          fifo_full,
   input logic          fifo_empty,
   input logic          tx_done,
   input logic          pop,
   input logic          busy,
   input logic [CW-1:0] count
);

   assert_break_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      break_force |-> !txd);

   assert_no_start_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (tx_enable && !fifo_empty));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_full_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && wr_en && !pop && !flush) |=> (fifo_full && $stable(count)));

   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty));

   assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fifo_empty && !busy && tx_done));

   assert_done_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (txd || break_force));

endmodule

bind uart_gap_tx uagt_tx_checker #(
   .DEPTH (FIFO_DEPTH),
   .CW    (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .flush       (flush),
   .tx_enable   (tx_enable),
   .break_force (break_force),
   .txd         (txd),
   .fifo_full   (fifo_full),
   .fifo_empty  (fifo_empty),
   .tx_done     (tx_done),
   .pop         (pop),
   .busy        (busy),
   .count       (count)
);

// File: tb/uart_gap_tx_bench.sv
`timescale 1ns/1ps
module uart_gap_tx_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       flush = 1'b0;
   logic       tx_enable = 1'b0;
   logic [2:0] parity_mode = '0;
   logic       break_force = 1'b0;
   logic [8:0] baud_div = '0;
   logic [3:0] gap_bits = '0;
   logic       txd, fifo_full, fifo_empty, tx_done;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int bitlen = 16;

   always #2 clk = ~clk;

   uart_gap_tx u_uart_gap_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
      .tx_enable(tx_enable), .parity_mode(parity_mode), .break_force(break_force),
      .baud_div(baud_div), .gap_bits(gap_bits), .txd(txd), .fifo_full(fifo_full),
      .fifo_empty(fifo_empty), .tx_done(tx_done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit par_present(input logic [2:0] m);
      return (m[2:1] != 2'b00);
   endfunction

   function automatic bit par_value(input logic [2:0] m, input logic [7:0] d);
      if (m == 3'b100) return ^d;
      if (m == 3'b101) return ~(^d);
      return m[0];
   endfunction

   task automatic push(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic watch_high(input int n, input string req);
      int lows = 0;
      repeat (n) begin
         @(negedge clk);
         if (txd !== 1'b1) lows++;
      end
      chk(lows == 0, req, lows, 0);
   endtask

   // Waits for a start bit and checks the whole frame at bit centres.
   // Returns the cycle at which the start bit was first seen low.
   task automatic expect_frame(input logic [7:0] d, input logic [2:0] m, output int t0);
      int guard = 0;
      @(negedge clk);
      while (txd !== 1'b0 && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      chk(guard < 20000, "R2 start bit seen", guard, 0);
      t0 = cyc;
      settle(bitlen / 2);
      chk(txd === 1'b0, "R2 start bit low", txd, 0);
      for (int i = 0; i < 8; i++) begin
         settle(bitlen);
         chk(txd === d[i], "R2 data bit lsb first", txd, d[i]);
      end
      if (par_present(m)) begin
         settle(bitlen);
         chk(txd === par_value(m, d), "R3 parity bit", txd, par_value(m, d));
      end
      settle(bitlen);
      chk(txd === 1'b1, "R2 stop bit high", txd, 1);
   endtask

   initial begin
      int t_a, t_b, t_c;
      logic [7:0] bytes [4];

      // R10 reset state
      settle(3);
      chk(txd === 1'b1, "R10 txd idle", txd, 1);
      chk(fifo_empty === 1'b1, "R10 empty", fifo_empty, 1);
      chk(fifo_full === 1'b0, "R10 full", fifo_full, 0);
      chk(tx_done === 1'b1, "R10 done", tx_done, 1);
      rst_n = 1'b1;
      settle(2);
      chk(txd === 1'b1 && tx_done === 1'b1, "R10 after release", txd, 1);

      // R2 R3 sweep of every parity mode at the fastest rate
      baud_div = 9'd0;
      bitlen = 16;
      gap_bits = 4'd0;
      tx_enable = 1'b1;
      for (int m = 0; m < 8; m++) begin
         parity_mode = m[2:0];
         for (int k = 0; k < 3; k++) begin
            logic [7:0] d;
            d = 8'(8'h5A + m * 37 + k * 91);
            push(d);
            expect_frame(d, parity_mode, t_a);
         end
         settle(bitlen * 2);
         chk(tx_done === 1'b1, "R6 done after frame", tx_done, 1);
      end

      // R1 R4 R6: back-to-back timing across rates and gaps
      for (int dv = 0; dv < 2; dv++) begin
         for (int g = 0; g < 4; g++) begin
            int gv;
            gv = (g == 3) ? 15 : g;
            tx_enable = 1'b0;
            baud_div = 9'(dv);
            bitlen = 16 * (dv + 1);
            gap_bits = 4'(gv);
            parity_mode = 3'b100;
            settle(4);
            push(8'h3C + 8'(g));
            push(8'hA1 ^ 8'(dv));
            push(8'h7E);
            tx_enable = 1'b1;
            expect_frame(8'h3C + 8'(g), parity_mode, t_a);
            expect_frame(8'hA1 ^ 8'(dv), parity_mode, t_b);
            chk(t_b - t_a == (11 + gv) * bitlen, "R4 R1 start spacing", t_b - t_a, (11 + gv) * bitlen);
            expect_frame(8'h7E, parity_mode, t_c);
            chk(t_c - t_b == (11 + gv) * bitlen, "R4 R1 start spacing", t_c - t_b, (11 + gv) * bitlen);
            chk(tx_done === 1'b0, "R6 not done in stop bit", tx_done, 0);
            settle(bitlen / 2 + 2);
            chk(tx_done === 1'b1, "R6 done after stop bit", tx_done, 1);
            settle(bitlen * (gv + 1));
         end
      end

      // R8 enable gate
      baud_div = 9'd0;
      bitlen = 16;
      gap_bits = 4'd1;
      parity_mode = 3'b000;
      tx_enable = 1'b0;
      settle(4);
      push(8'hC3);
      push(8'h18);
      watch_high(300, "R8 disabled line stays high");
      chk(tx_done === 1'b0, "R8 done low while queued", tx_done, 0);
      chk(fifo_empty === 1'b0, "R8 queue kept", fifo_empty, 0);
      tx_enable = 1'b1;
      expect_frame(8'hC3, parity_mode, t_a);
      expect_frame(8'h18, parity_mode, t_b);
      settle(bitlen * 3);

      // R9 full flag, dropped write, order
      tx_enable = 1'b0;
      gap_bits = 4'd0;
      parity_mode = 3'b101;
      bytes[0] = 8'h01; bytes[1] = 8'h80; bytes[2] = 8'hF0; bytes[3] = 8'h0F;
      push(bytes[0]);
      chk(fifo_empty === 1'b0 && fifo_full === 1'b0, "R9 one queued", fifo_full, 0);
      for (int i = 1; i < 4; i++) push(bytes[i]);
      chk(fifo_full === 1'b1, "R9 full at depth", fifo_full, 1);
      push(8'hEE);
      chk(fifo_full === 1'b1, "R9 still full", fifo_full, 1);
      tx_enable = 1'b1;
      for (int i = 0; i < 4; i++) expect_frame(bytes[i], parity_mode, t_a);
      watch_high(2000, "R9 dropped write never sent");
      chk(fifo_empty === 1'b1, "R9 empty after drain", fifo_empty, 1);

      // R5 break during a frame and while idle
      parity_mode = 3'b000;
      push(8'hFF);
      settle(40);
      break_force = 1'b1;
      begin
         int highs = 0;
         repeat (60) begin
            @(negedge clk);
            if (txd !== 1'b0) highs++;
         end
         chk(highs == 0, "R5 break in frame", highs, 0);
      end
      break_force = 1'b0;
      settle(bitlen * 12);
      break_force = 1'b1;
      settle(1);
      chk(txd === 1'b0, "R5 break while idle", txd, 0);
      break_force = 1'b0;
      settle(1);
      chk(txd === 1'b1, "R5 released idle high", txd, 1);

      // R7 flush in the middle of a frame
      tx_enable = 1'b0;
      push(8'h00);
      push(8'h55);
      push(8'hAA);
      tx_enable = 1'b1;
      begin
         int guard = 0;
         while (txd !== 1'b0 && guard < 1000) begin
            @(negedge clk);
            guard++;
         end
      end
      settle(30);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      chk(txd === 1'b1, "R7 line high after flush", txd, 1);
      chk(fifo_empty === 1'b1, "R7 queue emptied", fifo_empty, 1);
      chk(tx_done === 1'b1, "R7 done after flush", tx_done, 1);
      watch_high(2000, "R7 flushed bytes not sent");
      push(8'h96);
      expect_frame(8'h96, parity_mode, t_a);
      settle(bitlen * 2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule